// File: doc/BRIEF.md
# Switchable Dual-Rate Baud Clock Divider

This block derives the bit-timing strobes of a serial port from one master clock. A single select input picks between two rate families. The fast family uses a plain binary chain: a prescaler produces a tap strobe, and a binary divider turns that tap into the 16x sampling strobe. The slow family gets a nominal 110 baud from the same oscillator. It uses a non-binary branch that takes the same tap strobe and divides it by 350. That branch is a cascade of divide-by-10, divide-by-5 and divide-by-7 counters, and its output joins the fast path again just ahead of a shared divide-by-16 final stage.

Everything runs on the master clock. Each stage passes on a one-cycle enable pulse rather than a derived clock. The slow branch runs all the time, whichever rate is selected. The select input is registered, and it is only acted on in the cycle where the final stage wraps. A change of rate therefore never cuts a bit period short in the middle. The downstream receiver and transmitter use `sample_en` as their 16x oversampling strobe and `bit_en` as their bit boundary.

Top module: `baud_rate_divider`

## Requirements
- R1: While `rst` is high and after it has been sampled, `sample_en` and `bit_en` are both 0. Every counter clears to its first state. The registered rate selection loads from `rate_sel`, where 0 is fast and 1 is slow.
- R2: In fast mode, `sample_en` is a one-cycle pulse every PRE_DIV*FAST_DIV clocks, which is 16 clocks with the defaults.
- R3: In slow mode, `sample_en` is a one-cycle pulse every PRE_DIV*350 clocks, which is 700 clocks with the defaults.
- R4: The divide-by-5 stage of the slow branch steps through exactly five states, 0 to 4. It never reaches a sixth state.
- R5: The divide-by-7 stage of the slow branch steps through exactly seven states, 0 to 6, and then returns to 0.
- R6: `bit_en` marks every BIT_DIV-th (16th) `sample_en` pulse. The bit period is therefore 256 clocks in fast mode and 11200 clocks in slow mode.
- R7: The rate selection changes only at the clock edge that ends a cycle with `bit_en` high. At that edge `rate_sel` is sampled. A value of `rate_sel` present at any other edge has no effect.
- R8: The slow branch and the binary chain run freely from reset, in either mode. After a switch, the new rate's pulses keep their reset-relative phase. With edges counted from reset release as n, fast pulses fall on n mod 16 = 15 and slow pulses fall on n mod 700 = 699.
- R9: After reset release, the first `sample_en` comes one full sample period later, at edge count n = P-1. The first `bit_en` comes at n = 16P-1. P is the sample period of the selected rate.
- R10: `bit_en` is high only in a cycle where `sample_en` is also high, and it never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | Rate request: 0 fast family, 1 slow (110 baud) |
| sample_en | output | 1 | One-cycle 16x sampling strobe |
| bit_en | output | 1 | One-cycle bit boundary strobe |

## Verification
The interesting coincidence is a rate request that lands in the very cycle the final stage wraps. The bench holds a new `rate_sel` value in exactly the cycle its model predicts a `bit_en`. The next period must then follow the new rate at its reset-locked phase. The bench also pulses `rate_sel` for a single cycle away from any wrap, and the output must stay on the old rate. A behavioural model, built from modular arithmetic on the edge count, checks both outputs on every clock. Measured sample and bit intervals check the 350 ratio and the divide-by-16 ratio.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // Cascade of the non-binary slow branch (product 350)
  localparam int unsigned SLOW_STAGES = 3;
  localparam int unsigned SLOW_MODS [SLOW_STAGES] = '{10, 5, 7};

endpackage

// File: rtl/baud_mod_counter.sv
module baud_mod_counter #(
  parameter int unsigned MOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic wrap_o
);
  localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign wrap_o = en_i && (cnt_q == LAST);

  // Counter stays inside its MOD states (covers the divide-by-5 and divide-by-7 stages)
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // A wrap always returns the counter to its first state
  assert_wrap_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));

  // Without an enable the count holds
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/baud_slow_chain.sv
module baud_slow_chain
  import baud_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tap_en,
  output logic slow_en
);
  logic [SLOW_STAGES:0] link;

  assign link[0] = tap_en;

  for (genvar s = 0; s < SLOW_STAGES; s++) begin : g_stage
    baud_mod_counter #(.MOD(SLOW_MODS[s])) u_stage (
      .clk    (clk),
      .rst    (rst),
      .en_i   (link[s]),
      .wrap_o (link[s+1])
    );
  end

  assign slow_en = link[SLOW_STAGES];

  // A slow strobe can only appear together with a tap strobe
  assert_slow_needs_tap_R3: assert property (@(posedge clk) disable iff (rst)
    slow_en |-> tap_en);

endmodule

// File: rtl/baud_final_stage.sv
module baud_final_stage
  import baud_div_pkg::*;
#(
  parameter int unsigned BIT_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  input  logic fast_en,
  input  logic slow_en,
  output logic sample_en,
  output logic bit_en
);
  rate_e sel_q;

  always_ff @(posedge clk) begin
    if (rst || bit_en)
      sel_q <= rate_e'(rate_sel);
  end

  assign sample_en = (sel_q == RATE_SLOW) ? slow_en : fast_en;

  baud_mod_counter #(.MOD(BIT_DIV)) u_bitdiv (
    .clk    (clk),
    .rst    (rst),
    .en_i   (sample_en),
    .wrap_o (bit_en)
  );

  // Selection moves only at a final-stage wrap
  assert_sel_only_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sel_q));

  // Bit strobe only rides on a sampling strobe
  assert_bit_on_sample_R10: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> sample_en);

  // Bit strobe is a single-cycle pulse
  assert_bit_single_R10: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> !bit_en);

endmodule

// File: rtl/baud_rate_divider.sv
module baud_rate_divider
  import baud_div_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 2,
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned BIT_DIV  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  output logic sample_en,
  output logic bit_en
);
  logic tap_en;
  logic fast_en;
  logic slow_en;

  baud_mod_counter #(.MOD(PRE_DIV)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .en_i   (1'b1),
    .wrap_o (tap_en)
  );

  baud_mod_counter #(.MOD(FAST_DIV)) u_fastdiv (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tap_en),
    .wrap_o (fast_en)
  );

  baud_slow_chain u_slow (
    .clk     (clk),
    .rst     (rst),
    .tap_en  (tap_en),
    .slow_en (slow_en)
  );

  baud_final_stage #(.BIT_DIV(BIT_DIV)) u_final (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .fast_en   (fast_en),
    .slow_en   (slow_en),
    .sample_en (sample_en),
    .bit_en    (bit_en)
  );

  // Outputs stay quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    ($past(rst) && rst) |-> (!sample_en && !bit_en));

  // Sampling strobe is a single-cycle pulse
  assert_sample_single_R2: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> !sample_en);

endmodule

// File: tb/baud_rate_divider_bench.sv
module baud_rate_divider_bench;

  localparam int PRE   = 2;
  localparam int FASTP = PRE * 8;
  localparam int SLOWP = PRE * 350;
  localparam int BITS  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b0;
  logic sample_en, bit_en;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  baud_rate_divider u_baud_rate_divider (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .sample_en (sample_en),
    .bit_en    (bit_en)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model state
  int  n = 0;          // edges since reset release
  int  fin = 0;        // final-stage count
  logic msel = 1'b0;   // selected rate
  bit  exp_s, exp_b;
  int  last_s = -1, last_b = -1;
  int  bits_same = 0;
  bit  first_s_seen, first_b_seen;
  bit  armed = 1'b0;

  initial begin : watchdog
    #(300000 * 5ns);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 58000; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        if (rst) begin
          check("R1 sample_en in reset", sample_en, 0);
          check("R1 bit_en in reset", bit_en, 0);
          first_s_seen = 0; first_b_seen = 0;
          last_s = -1; last_b = -1; bits_same = 0;
          exp_s = 0; exp_b = 0;
        end else begin
          exp_s = msel ? ((n % SLOWP) == SLOWP - 1) : ((n % FASTP) == FASTP - 1);
          exp_b = exp_s && (fin == BITS - 1);
          check("R7 R8 sample_en vs model", sample_en, exp_s);
          check("R6 R7 bit_en vs model", bit_en, exp_b);
          if (bit_en) check("R10 bit_en without sample_en", sample_en, 1);
          if (sample_en && !first_s_seen) begin
            first_s_seen = 1;
            check("R9 first sample_en edge", n, (msel ? SLOWP : FASTP) - 1);
          end
          if (bit_en && !first_b_seen) begin
            first_b_seen = 1;
            check("R9 first bit_en edge", n, BITS * (msel ? SLOWP : FASTP) - 1);
          end
          if (sample_en) begin
            if (last_s >= 0 && bits_same >= 1)
              check(msel ? "R3 R4 R5 slow sample interval" : "R2 fast sample interval",
                    n - last_s, msel ? SLOWP : FASTP);
            last_s = n;
          end
          if (bit_en) begin
            if (last_b >= 0 && bits_same >= 2)
              check("R6 bit interval", n - last_b, BITS * (msel ? SLOWP : FASTP));
            last_b = n;
          end
        end
      end

      // Stimulus for the next edge
      if (k == 4) rst = 1'b0;
      if (k == 200) rate_sel = exp_b ? 1'b0 : 1'b1;   // one-cycle pulse away from a wrap (R7)
      if (k == 201) rate_sel = 1'b0;
      if (k == 1000) rate_sel = 1'b1;                  // held request, taken at next wrap
      if (k == 40000) armed = 1'b1;
      if (armed && exp_b && !rst) begin                // request coinciding with a wrap
        rate_sel = 1'b0;
        armed = 1'b0;
      end
      if (k == 44000) begin rst = 1'b1; rate_sel = 1'b1; end
      if (k == 44003) rst = 1'b0;                      // restart directly in slow mode

      // Model advance for the coming edge
      if (rst) begin
        n = 0; fin = 0; msel = rate_sel; bits_same = 0;
      end else begin
        if (exp_b) begin
          if (msel != rate_sel) bits_same = 0;
          else bits_same++;
          msel = rate_sel;
        end
        if (exp_s) fin = (fin + 1) % BITS;
        n++;
      end
    end
    check("R1 R9 bit seen after restart", int'(first_b_seen), 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule